// File: doc/BRIEF.md
# Configurable UART Line-Format Transmitter

This block is the transmit half of a serial port whose character framing is chosen at run time through an 8-bit line-control register. A producer hands over one character at a time with a valid/ready handshake. The block then drives a frame onto the serial line. The frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a stop period of one, one and a half or two bit times. Between frames the line rests high.

Bit timing comes from an external single-cycle baud tick. Each bit time is `OVERSAMPLE` ticks long, which makes a half-bit stop period exact. The control register also holds a break flag that pulls the line low whenever it is set. A divisor-latch select flag in bit 7 is stored and presented on the register output for a neighbouring divider; inside this block it does nothing. The format fields are captured when a frame begins, so a write made during a frame shapes only the frames that follow.

Top module: `uart_fmt_tx`

## Requirements
- R1: After reset the serial output is 1, `in_ready` is 1 and `lcr_q` reads 0.
- R2: A frame is one bit time at 0 (start), then the data bits least significant first; `lcr_q[1:0]` sets the data width: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8 bits. Data bits above the chosen width are not sent.
- R3: With `lcr_q[2]`=0 the stop period is one bit time. With `lcr_q[2]`=1 it is two bit times, except when `lcr_q[1:0]`=00, where it is one and a half bit times. The stop level is 1.
- R4: With `lcr_q[3]`=0 no parity bit is sent. With `lcr_q[3]`=1 one parity bit follows the last data bit.
- R5: `lcr_q[5:4]` picks the parity bit: 00 makes the count of ones over the data and parity bits odd, 01 makes it even, 10 sends a constant 1, 11 sends a constant 0.
- R6: While `lcr_q[6]` is 1 the serial output is 0, whether idle or mid-frame, and the timing of a frame in progress does not change.
- R7: A write stores all eight bits of `lcr_wd` in `lcr_q` at the next edge. Bit 7 has no effect on the frame sent.
- R8: `in_ready` falls at the edge that accepts a character and stays low until the baud tick that ends the last stop bit. The frame lasts exactly (1 + data bits + parity bits) x `OVERSAMPLE` ticks plus the stop period.
- R9: The format fields are taken from `lcr_q` at the edge that accepts a character. A write during a frame leaves that frame unchanged and applies from the next one.
- R10: When idle and not in break, the serial output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_we | input | 1 | Line-control register write strobe |
| lcr_wd | input | 8 | Line-control write data |
| lcr_q | output | 8 | Line-control register contents |
| baud_tick | input | 1 | One-cycle pulse, OVERSAMPLE per bit time |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial output |

## Verification
The bench builds the block with `OVERSAMPLE` set to 4 and the registered output enabled. The short bit time keeps each frame to a few dozen ticks, so several hundred frames fit in the run. At that setting the half-bit stop period is two ticks, so an error of one tick in the one-and-a-half stop mode changes the measured frame length. With a tick every third clock there is room to sample each bit in its middle, after the output register has settled. It is also possible to rewrite the register partway through a frame and see the effect at the very next sampled bit.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

   // Line-control layout; field positions are decoded by neighbours
   typedef struct packed {
      logic       dl_sel;    // bit 7: divisor-latch select, passed through
      logic       brk;       // bit 6: force line low
      logic [1:0] par_kind;  // bits 5:4
      logic       par_en;    // bit 3
      logic       stop_x;    // bit 2: extended stop period
      logic [1:0] wlen;      // bits 1:0: width code
   } line_ctl_t;

   localparam int CTL_W    = $bits(line_ctl_t);
   localparam int MAX_CHAR = 8;
   localparam int SYM_W    = 4;                 // frame symbol index width
   localparam int PAT_W    = 1 << SYM_W;        // symbol pattern storage

   localparam logic [1:0] PAR_ODD  = 2'b00;
   localparam logic [1:0] PAR_EVEN = 2'b01;
   localparam logic [1:0] PAR_ONE  = 2'b10;
   localparam logic [1:0] PAR_ZERO = 2'b11;

   typedef enum logic [1:0] {STOP_ONE, STOP_ONE_HALF, STOP_TWO} stop_len_e;

   function automatic logic [SYM_W-1:0] char_bits(input logic [1:0] code);
      return SYM_W'(5) + SYM_W'(code);
   endfunction

endpackage

// File: rtl/uart_fmt_ctl.sv
module uart_fmt_ctl
   import uart_fmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wd,
   output line_ctl_t        ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl <= '0;
      else if (we)
         ctl <= line_ctl_t'(wd);
   end

endmodule

// File: rtl/uart_fmt_frame.sv
module uart_fmt_frame
   import uart_fmt_pkg::*;
(
   input  line_ctl_t             ctl,
   input  logic [MAX_CHAR-1:0]   data,
   output logic [PAT_W-1:0]      pattern,
   output logic [SYM_W-1:0]      nsym,
   output stop_len_e             stop_len
);

   logic [SYM_W-1:0]    nch;
   logic [MAX_CHAR-1:0] kept;
   logic                ones_odd;
   logic                par_bit;

   assign nch = char_bits(ctl.wlen);

   // Mask off bits above the selected width before the parity sum
   for (genvar j = 0; j < MAX_CHAR; j++) begin : g_mask
      assign kept[j] = (SYM_W'(j) < nch) ? data[j] : 1'b0;
   end

   assign ones_odd = ^kept;

   always_comb begin
      unique case (ctl.par_kind)
         PAR_ODD:  par_bit = ~ones_odd;
         PAR_EVEN: par_bit =  ones_odd;
         PAR_ONE:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   // Symbol 0 is the start bit; unused positions stay at the stop level
   always_comb begin
      pattern    = '1;
      pattern[0] = 1'b0;
      for (int i = 0; i < MAX_CHAR; i++)
         if (SYM_W'(i) < nch)
            pattern[i+1] = data[i];
      if (ctl.par_en)
         pattern[nch + SYM_W'(1)] = par_bit;
   end

   assign nsym = SYM_W'(1) + nch + SYM_W'(ctl.par_en);

   always_comb begin
      if (!ctl.stop_x)
         stop_len = STOP_ONE;
      else if (ctl.wlen == 2'b00)
         stop_len = STOP_ONE_HALF;
      else
         stop_len = STOP_TWO;
   end

endmodule

// File: rtl/uart_fmt_seq.sv
module uart_fmt_seq
   import uart_fmt_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [PAT_W-1:0] pattern,
   input  logic [SYM_W-1:0] nsym,
   input  stop_len_e        stop_len,
   output logic             busy,
   output logic             line
);

   localparam int OS_LG = $clog2(OVERSAMPLE);
   localparam int CNT_W = OS_LG + SYM_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] last_n;
   logic [CNT_W-1:0] stop_ticks;
   logic [PAT_W-1:0] pat_q;
   logic [SYM_W-1:0] idx;

   always_comb begin
      unique case (stop_len)
         STOP_ONE:      stop_ticks = CNT_W'(OVERSAMPLE);
         STOP_ONE_HALF: stop_ticks = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
         default:       stop_ticks = CNT_W'(2 * OVERSAMPLE);
      endcase
   end

   // Whole frame is one tick count; the symbol index is its upper part
   assign last_n = (CNT_W'(nsym) << OS_LG) + stop_ticks - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         last_q <= '0;
         pat_q  <= '1;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            last_q <= last_n;
            pat_q  <= pattern;
         end
      end else if (tick) begin
         if (cnt == last_q)
            busy <= 1'b0;
         else
            cnt <= cnt + CNT_W'(1);
      end
   end

   assign idx  = cnt[OS_LG +: SYM_W];
   assign line = !busy || pat_q[idx];

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
   import uart_fmt_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lcr_we,
   input  logic [CTL_W-1:0]    lcr_wd,
   output logic [CTL_W-1:0]    lcr_q,
   input  logic                baud_tick,
   input  logic                in_valid,
   input  logic [MAX_CHAR-1:0] in_data,
   output logic                in_ready,
   output logic                txd
);

   if (OVERSAMPLE < 2 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be a power of two of at least 2");
   end
   if (CTL_W != 8) begin : g_bad_ctl
      $error("line-control register must be 8 bits");
   end

   line_ctl_t        ctl;
   logic [PAT_W-1:0] pattern;
   logic [SYM_W-1:0] nsym;
   stop_len_e        stop_len;
   logic             busy;
   logic             line;
   logic             txd_n;

   uart_fmt_ctl u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (lcr_we),
      .wd   (lcr_wd),
      .ctl  (ctl)
   );

   uart_fmt_frame u_frame (
      .ctl     (ctl),
      .data    (in_data),
      .pattern (pattern),
      .nsym    (nsym),
      .stop_len(stop_len)
   );

   uart_fmt_seq #(.OVERSAMPLE(OVERSAMPLE)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .start   (in_valid && !busy),
      .pattern (pattern),
      .nsym    (nsym),
      .stop_len(stop_len),
      .busy    (busy),
      .line    (line)
   );

   assign lcr_q    = ctl;
   assign in_ready = !busy;
   assign txd_n    = ctl.brk ? 1'b0 : line;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            txd <= 1'b1;
         else
            txd <= txd_n;
      end
   end else begin : g_out_comb
      assign txd = txd_n;
   end

endmodule

// File: rtl/uart_fmt_tx_chk.sv
module uart_fmt_tx_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       lcr_we,
   input logic [7:0] lcr_wd,
   input logic [7:0] lcr_q,
   input logic       baud_tick,
   input logic       in_valid,
   input logic       in_ready,
   input logic       txd
);

   logic brk_d;
   logic idle_d;
   logic brk_e;
   logic idle_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_d  <= 1'b0;
         idle_d <= 1'b1;
      end else begin
         brk_d  <= lcr_q[6];
         idle_d <= in_ready;
      end
   end

   // Line state that the output currently reflects
   assign brk_e  = OUT_REG ? brk_d  : lcr_q[6];
   assign idle_e = OUT_REG ? idle_d : in_ready;

   p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_e |-> !txd);

   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_e && !brk_e) |-> txd);

   p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !baud_tick) |=> !in_ready);

   p_ctl_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lcr_we |=> (lcr_q == $past(lcr_wd)));

   p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lcr_we |=> $stable(lcr_q));

endmodule

bind uart_fmt_tx uart_fmt_tx_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lcr_we   (lcr_we),
   .lcr_wd   (lcr_wd),
   .lcr_q    (lcr_q),
   .baud_tick(baud_tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .txd      (txd)
);

// File: tb/uart_fmt_tx_tb.sv
module uart_fmt_tx_tb;

   localparam int OS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lcr_we = 1'b0;
   logic [7:0] lcr_wd = '0;
   logic [7:0] lcr_q;
   logic       baud_tick;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       txd;

   int n_chk  = 0;
   int n_fail = 0;
   int tdiv   = 0;

   always #2 clk = ~clk;

   always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
   assign baud_tick = rst_n && (tdiv == 0);

   uart_fmt_tx #(.OVERSAMPLE(OS), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_wd(lcr_wd), .lcr_q(lcr_q),
      .baud_tick(baud_tick), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .txd(txd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Reference model of the frame format
   function automatic int f_nch(input logic [7:0] f);
      return 5 + int'(f[1:0]);
   endfunction
   function automatic int f_nsym(input logic [7:0] f);
      return 1 + f_nch(f) + int'(f[3]);
   endfunction
   function automatic int f_stop(input logic [7:0] f);
      if (!f[2]) return OS;
      return (f[1:0] == 2'b00) ? OS + OS / 2 : 2 * OS;
   endfunction
   function automatic logic f_bit(input logic [7:0] d, input logic [7:0] f, input int i);
      int n = f_nch(f);
      int ones = 0;
      if (i == 0) return 1'b0;
      if (i <= n) return d[i-1];
      if (f[3] && i == n + 1) begin
         for (int b = 0; b < n; b++) ones += int'(d[b]);
         case (f[5:4])
            2'b00:   return (ones % 2) == 0;
            2'b01:   return (ones % 2) == 1;
            2'b10:   return 1'b1;
            default: return 1'b0;
         endcase
      end
      return 1'b1;
   endfunction

   task automatic lcr_write(input logic [7:0] v);
      @(negedge clk); lcr_we = 1'b1; lcr_wd = v;
      @(negedge clk); lcr_we = 1'b0;
   endtask

   // Sends one character; optionally rewrites the register one bit time in
   task automatic run_frame(input logic [7:0] d, input logic [7:0] fmt,
                            input bit mid_wr, input logic [7:0] mid_val, input string tag);
      int nsym = f_nsym(fmt);
      int tot  = nsym * OS + f_stop(fmt);
      int k = 0;
      int pend = -1;
      bit rdy_ok = 1'b1;
      bit brk = 1'b0;
      while (!in_ready) @(negedge clk);
      @(negedge clk); in_valid = 1'b1; in_data = d;
      @(posedge clk); #1; in_valid = 1'b0;
      while (k < tot) begin
         @(posedge clk); #1;
         lcr_we = 1'b0;
         if (pend >= 0) begin
            logic e = brk ? 1'b0 : f_bit(d, fmt, pend);
            string r;
            if (tag != "") r = tag;
            else if (pend == 0 || pend <= f_nch(fmt)) r = "R2 data/start";
            else if (pend < nsym) r = "R5 parity";
            else r = "R3 stop";
            check(txd === e, $sformatf("%s bit %0d fmt %02h", r, pend, fmt), int'(txd), int'(e));
            pend = -1;
         end
         if (baud_tick) begin
            k++;
            if (k % OS == OS / 2) pend = k / OS;
            if (mid_wr && k == OS + 1) begin
               lcr_we = 1'b1; lcr_wd = mid_val;
               brk = mid_val[6];
            end
         end
         if (k < tot && in_ready) rdy_ok = 1'b0;
      end
      check(rdy_ok, $sformatf("R8 ready low during frame fmt %02h", fmt), 0, 1);
      check(in_ready === 1'b1,
            $sformatf("R3 R4 R8 frame length %0d ticks fmt %02h", tot, fmt), int'(in_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      report();
   end

   initial begin
      void'($urandom(32'h1b2c3d4e));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
      check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
      check(lcr_q === 8'h00, "R1 lcr_q after reset", int'(lcr_q), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(txd === 1'b1, "R10 idle line high", int'(txd), 1);

      // R6: break while idle, then release
      lcr_write(8'h40);
      repeat (3) @(negedge clk);
      check(txd === 1'b0, "R6 break while idle", int'(txd), 0);
      lcr_write(8'h00);
      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R10 idle after break released", int'(txd), 1);

      // R7: all bits stored and read back
      lcr_write(8'hA5);
      check(lcr_q === 8'hA5, "R7 register readback", int'(lcr_q), 'hA5);

      // Directed formats
      lcr_write(8'h00); run_frame(8'hE6, 8'h00, 1'b0, 8'h00, "");   // R2 5-bit, upper bits dropped
      lcr_write(8'h04); run_frame(8'h15, 8'h04, 1'b0, 8'h00, "");   // R3 one and a half stop
      lcr_write(8'h07); run_frame(8'h5A, 8'h07, 1'b0, 8'h00, "");   // R3 two stop
      lcr_write(8'h0B); run_frame(8'h7F, 8'h0B, 1'b0, 8'h00, "");   // R5 odd
      lcr_write(8'h1B); run_frame(8'hFF, 8'h1B, 1'b0, 8'h00, "");   // R5 even
      lcr_write(8'h2A); run_frame(8'h00, 8'h2A, 1'b0, 8'h00, "");   // R5 stick one
      lcr_write(8'h3A); run_frame(8'hFF, 8'h3A, 1'b0, 8'h00, "");   // R5 stick zero
      lcr_write(8'h33); run_frame(8'hFF, 8'h33, 1'b0, 8'h00, "");   // R4 parity off
      lcr_write(8'h83); run_frame(8'hC3, 8'h83, 1'b0, 8'h00, "R7 dl_sel set"); // R7

      // R9: mid-frame write does not alter this frame, applies to the next
      lcr_write(8'h03);
      run_frame(8'hA6, 8'h03, 1'b1, 8'h1C, "R9 old format kept");
      check(lcr_q === 8'h1C, "R9 new value stored", int'(lcr_q), 'h1C);
      run_frame(8'h0D, 8'h1C, 1'b0, 8'h00, "R9 new format used");

      // R6: break raised mid-frame; timing unchanged
      lcr_write(8'h0F);
      run_frame(8'hFF, 8'h0F, 1'b1, 8'h4F, "R6 break in frame");
      lcr_write(8'h0F);
      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R10 idle after break frame", int'(txd), 1);

      // Random formats and data
      for (int n = 0; n < 200; n++) begin
         logic [7:0] f = 8'($urandom) & 8'hBF;
         logic [7:0] d = 8'($urandom);
         lcr_write(f);
         run_frame(d, f, 1'b0, 8'h00, "");
      end
      report();
   end

endmodule